// File: doc/BRIEF.md
# Code-Region Bus Interface Router with Alias Remap

This block sits between a processor core and three outgoing master ports: an instruction-code port, a data-code port and a system port. Each cycle the core may present one request with an address, a fetch flag, a debug flag and a write flag. The block picks exactly one destination from the address region and the kind of access, and presents the request on that port one clock later. Addresses in a small internal window reach no port. For those addresses the block raises an internal-hit flag instead.

A two-bit alias-select register chooses which memory (flash, boot ROM or SRAM) appears in the low alias window. Software may rewrite it at any time. For an address inside that window the block forwards the translated physical address, which is the selected memory's base plus the offset. The port is still chosen from the address the core issued. As a result, SRAM reached through the alias travels over a code port, while the same SRAM word reached at its own address travels over the system port.

Top module: `code_bus_router`

## Requirements
- R1: While rst_n is low and on the first cycle after it, every port valid and int_hit are low and remap_sel reads 2'b00 (flash).
- R2: A request with req_fetch=1 and req_debug=0 whose address is in 0x00000000..0x1FFFFFFC appears on the instruction-code port (ic_valid, ic_addr) exactly one cycle after it is presented.
- R3: Any other request below 0x20000000 goes to the data-code port with its write and debug flags. This covers data accesses, debug accesses (debug overrides fetch) and fetches to 0x1FFFFFFD..0x1FFFFFFF.
- R4: Requests to 0x20000000..0xDFFFFFFF and 0xE0100000..0xFFFFFFFF go to the system port with the address unchanged and the write and debug flags carried.
- R5: Requests to 0xE0000000..0xE00FFFFF drive no port valid and set int_hit for one cycle.
- R6: An address in the alias window 0x00000000..0x03FFFFFF is forwarded as base + address. The base is 0x08000000 when remap_sel=2'b00 (flash), 0x1FFF0000 when remap_sel=2'b01 (boot ROM) and 0x20000000 when remap_sel=2'b11 (SRAM).
- R7: With SRAM selected, alias address 0x00000004 goes out on a code port as 0x20000004. A request to 0x20000004 still goes to the system port with the same address.
- R8: Addresses 0x04000000..0x1FFFFFFF, including flash at 0x08000000, stay on the code ports untranslated under every alias selection.
- R9: A write of the reserved value 2'b10 to the alias-select register is ignored, and remap_sel keeps its value.
- R10: A write to the alias-select register affects requests from the following cycle on. A request in the same cycle as the write uses the previous selection.
- R11: A cycle with req_valid=0 produces no port valid and no int_hit in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_addr | input | 32 | Request address |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data |
| req_debug | input | 1 | Debug access |
| req_write | input | 1 | Write access |
| remap_we | input | 1 | Alias-select write strobe |
| remap_wdata | input | 2 | Alias-select write value |
| remap_sel | output | 2 | Current alias selection |
| ic_valid | output | 1 | Instruction-code port request |
| ic_addr | output | 32 | Instruction-code port address |
| dc_valid | output | 1 | Data-code port request |
| dc_addr | output | 32 | Data-code port address |
| dc_write | output | 1 | Data-code port write |
| dc_debug | output | 1 | Data-code port debug flag |
| sys_valid | output | 1 | System port request |
| sys_addr | output | 32 | System port address |
| sys_write | output | 1 | System port write |
| sys_debug | output | 1 | System port debug flag |
| int_hit | output | 1 | Request fell in the internal window |

## Verification
A stale or corrupted alias selection shows on the next request into the alias window: the forwarded address carries the wrong base. A decode error shows up as the wrong valid strobe, or as two strobes at once. Both kinds of fault appear on the cycle after the request, so the bench probes each region edge and each selection with a request that is compared one cycle later. The bench also writes the selection in the same cycle as a request, to catch an update that takes effect a cycle early.

// File: rtl/cbr_pkg.sv
// Shared types for the code-region bus router.
// Assumes a 2-bit alias-select encoding with one reserved code.
package cbr_pkg;
    typedef enum logic [1:0] {
        SEL_FLASH = 2'b00,
        SEL_ROM   = 2'b01,
        SEL_RSVD  = 2'b10,
        SEL_SRAM  = 2'b11
    } alias_sel_e;

    typedef enum logic [2:0] {
        DST_NONE     = 3'd0,
        DST_ICODE    = 3'd1,
        DST_DCODE    = 3'd2,
        DST_SYSTEM   = 3'd3,
        DST_INTERNAL = 3'd4
    } dest_e;
endpackage

// File: rtl/cbr_alias_reg.sv
// Alias-select register: holds which memory answers in the low alias window.
// Assumes writes of the reserved code must leave the held value untouched.
module cbr_alias_reg
    import cbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [1:0] wdata,
    output alias_sel_e sel_q
);
    // Capture legal codes only; reset selects flash.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= SEL_FLASH;
        else if (we && (wdata != SEL_RSVD))
            sel_q <= alias_sel_e'(wdata);
    end

    // R9
    rsvd_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata == SEL_RSVD) |=> $stable(sel_q));

    // R9
    never_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q != SEL_RSVD);
endmodule

// File: rtl/cbr_region_decode.sv
// Region decoder: picks a destination port from address and access kind.
// Assumes a debug access is treated as a data access even if fetch is set.
module cbr_region_decode
    import cbr_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] CODE_END   = 32'h2000_0000,
    parameter logic [31:0] FETCH_LAST = 32'h1FFF_FFFC,
    parameter logic [31:0] INT_LO     = 32'hE000_0000,
    parameter logic [31:0] INT_HI     = 32'hE00F_FFFF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              fetch,
    input  logic              debug,
    output dest_e             dest
);
    localparam logic [ADDR_W-1:0] CODE_END_W   = CODE_END[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] FETCH_LAST_W = FETCH_LAST[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] INT_LO_W     = INT_LO[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] INT_HI_W     = INT_HI[ADDR_W-1:0];

    // Classify the address into one destination.
    always_comb begin
        if (addr >= INT_LO_W && addr <= INT_HI_W)
            dest = DST_INTERNAL;
        else if (addr < CODE_END_W)
            dest = (fetch && !debug && addr <= FETCH_LAST_W) ? DST_ICODE : DST_DCODE;
        else
            dest = DST_SYSTEM;
    end
endmodule

// File: rtl/cbr_alias_xlate.sv
// Alias translator: maps an address in the low window onto the selected memory.
// Assumes the window is a power of two starting at address zero.
module cbr_alias_xlate
    import cbr_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          ALIAS_BITS = 26,
    parameter logic [31:0] FLASH_BASE = 32'h0800_0000,
    parameter logic [31:0] ROM_BASE   = 32'h1FFF_0000,
    parameter logic [31:0] SRAM_BASE  = 32'h2000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  alias_sel_e        sel,
    output logic [ADDR_W-1:0] phys
);
    localparam int HI_W = ADDR_W - ALIAS_BITS;

    logic              in_alias;
    logic [ADDR_W-1:0] base;

    // Window hit when all bits above the window are zero.
    always_comb in_alias = (addr[ADDR_W-1:ALIAS_BITS] == {HI_W{1'b0}});

    // Pick the base of the selected memory.
    always_comb begin
        unique case (sel)
            SEL_ROM:  base = ROM_BASE[ADDR_W-1:0];
            SEL_SRAM: base = SRAM_BASE[ADDR_W-1:0];
            default:  base = FLASH_BASE[ADDR_W-1:0];
        endcase
    end

    // Add the window offset to the base for aliased addresses.
    always_comb
        phys = in_alias ? (base + {{HI_W{1'b0}}, addr[ALIAS_BITS-1:0]}) : addr;
endmodule

// File: rtl/code_bus_router.sv
// Top of the code-region router: decodes, translates and registers one
// request per cycle onto one of three ports or the internal-hit flag.
// Assumes ports accept every request (no back-pressure in this block).
module code_bus_router
    import cbr_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          ALIAS_BITS = 26,
    parameter logic [31:0] CODE_END   = 32'h2000_0000,
    parameter logic [31:0] FETCH_LAST = 32'h1FFF_FFFC,
    parameter logic [31:0] INT_LO     = 32'hE000_0000,
    parameter logic [31:0] INT_HI     = 32'hE00F_FFFF,
    parameter logic [31:0] FLASH_BASE = 32'h0800_0000,
    parameter logic [31:0] ROM_BASE   = 32'h1FFF_0000,
    parameter logic [31:0] SRAM_BASE  = 32'h2000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_fetch,
    input  logic              req_debug,
    input  logic              req_write,
    input  logic              remap_we,
    input  logic [1:0]        remap_wdata,
    output logic [1:0]        remap_sel,
    output logic              ic_valid,
    output logic [ADDR_W-1:0] ic_addr,
    output logic              dc_valid,
    output logic [ADDR_W-1:0] dc_addr,
    output logic              dc_write,
    output logic              dc_debug,
    output logic              sys_valid,
    output logic [ADDR_W-1:0] sys_addr,
    output logic              sys_write,
    output logic              sys_debug,
    output logic              int_hit
);
    localparam logic [ADDR_W-1:0] CODE_END_W   = CODE_END[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] FETCH_LAST_W = FETCH_LAST[ADDR_W-1:0];

    alias_sel_e        sel_q;
    dest_e             dest;
    logic [ADDR_W-1:0] phys;

    cbr_alias_reg u_alias_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (remap_we),
        .wdata (remap_wdata),
        .sel_q (sel_q)
    );

    cbr_region_decode #(
        .ADDR_W     (ADDR_W),
        .CODE_END   (CODE_END),
        .FETCH_LAST (FETCH_LAST),
        .INT_LO     (INT_LO),
        .INT_HI     (INT_HI)
    ) u_decode (
        .addr  (req_addr),
        .fetch (req_fetch),
        .debug (req_debug),
        .dest  (dest)
    );

    cbr_alias_xlate #(
        .ADDR_W     (ADDR_W),
        .ALIAS_BITS (ALIAS_BITS),
        .FLASH_BASE (FLASH_BASE),
        .ROM_BASE   (ROM_BASE),
        .SRAM_BASE  (SRAM_BASE)
    ) u_xlate (
        .addr (req_addr),
        .sel  (sel_q),
        .phys (phys)
    );

    // Expose the held selection.
    always_comb remap_sel = sel_q;

    // Register the routed request onto its port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ic_valid  <= 1'b0;
            ic_addr   <= '0;
            dc_valid  <= 1'b0;
            dc_addr   <= '0;
            dc_write  <= 1'b0;
            dc_debug  <= 1'b0;
            sys_valid <= 1'b0;
            sys_addr  <= '0;
            sys_write <= 1'b0;
            sys_debug <= 1'b0;
            int_hit   <= 1'b0;
        end else begin
            ic_valid  <= req_valid && (dest == DST_ICODE);
            dc_valid  <= req_valid && (dest == DST_DCODE);
            sys_valid <= req_valid && (dest == DST_SYSTEM);
            int_hit   <= req_valid && (dest == DST_INTERNAL);
            ic_addr   <= phys;
            dc_addr   <= phys;
            dc_write  <= req_write;
            dc_debug  <= req_debug;
            sys_addr  <= req_addr;
            sys_write <= req_write;
            sys_debug <= req_debug;
        end
    end

    // R3
    one_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ic_valid, dc_valid, sys_valid, int_hit}));

    // R2
    fetch_to_icode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fetch && !req_debug && req_addr <= FETCH_LAST_W) |=> ic_valid);

    // R4
    sys_never_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_valid |-> (sys_addr >= CODE_END_W));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(ic_valid || dc_valid || sys_valid || int_hit));
endmodule

// File: tb/code_bus_router_tb.sv
module code_bus_router_tb;
    localparam int P_NONE = 0, P_IC = 1, P_DC = 2, P_SYS = 3, P_INT = 4, P_MULTI = 7;

    typedef struct {
        int          port;
        logic [31:0] addr;
        logic        wr;
        logic        dbg;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_fetch = 1'b0;
    logic        req_debug = 1'b0;
    logic        req_write = 1'b0;
    logic        remap_we = 1'b0;
    logic [1:0]  remap_wdata = '0;
    logic [1:0]  remap_sel;
    logic        ic_valid, dc_valid, sys_valid, int_hit;
    logic [31:0] ic_addr, dc_addr, sys_addr;
    logic        dc_write, dc_debug, sys_write, sys_debug;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic [1:0] model_sel = 2'b00;
    exp_t q[$];

    always #5 clk = ~clk;

    code_bus_router u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_fetch(req_fetch), .req_debug(req_debug), .req_write(req_write),
        .remap_we(remap_we), .remap_wdata(remap_wdata), .remap_sel(remap_sel),
        .ic_valid(ic_valid), .ic_addr(ic_addr), .dc_valid(dc_valid),
        .dc_addr(dc_addr), .dc_write(dc_write), .dc_debug(dc_debug),
        .sys_valid(sys_valid), .sys_addr(sys_addr), .sys_write(sys_write),
        .sys_debug(sys_debug), .int_hit(int_hit)
    );

    function automatic logic [31:0] base_of(logic [1:0] s);
        case (s)
            2'b01:   return 32'h1FFF_0000;
            2'b11:   return 32'h2000_0000;
            default: return 32'h0800_0000;
        endcase
    endfunction

    function automatic exp_t model(logic [31:0] a, logic f, logic d, logic w,
                                   logic [1:0] s, string tag);
        exp_t e;
        e.tag = tag; e.wr = w; e.dbg = d;
        if (a >= 32'hE000_0000 && a <= 32'hE00F_FFFF) e.port = P_INT;
        else if (a < 32'h2000_0000) e.port = (f && !d && a <= 32'h1FFF_FFFC) ? P_IC : P_DC;
        else e.port = P_SYS;
        e.addr = (a < 32'h0400_0000) ? base_of(s) + a : a;
        return e;
    endfunction

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic send(logic [31:0] a, logic f, logic d, logic w, string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_fetch = f; req_debug = d; req_write = w;
        remap_we = 1'b0;
        q.push_back(model(a, f, d, w, model_sel, tag));
    endtask

    task automatic idle(string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b0; remap_we = 1'b0;
        e.port = P_NONE; e.addr = '0; e.wr = 1'b0; e.dbg = 1'b0; e.tag = tag;
        q.push_back(e);
    endtask

    // Write the alias select; optionally with a request in the same cycle.
    task automatic set_sel(logic [1:0] v, bit with_req, logic [31:0] a, string tag);
        exp_t e;
        @(negedge clk);
        remap_we = 1'b1; remap_wdata = v;
        req_valid = with_req; req_addr = a; req_fetch = 1'b1; req_debug = 1'b0; req_write = 1'b0;
        if (with_req) e = model(a, 1'b1, 1'b0, 1'b0, model_sel, tag);
        else begin
            e.port = P_NONE; e.addr = '0; e.wr = 1'b0; e.dbg = 1'b0; e.tag = tag;
        end
        q.push_back(e);
        if (v != 2'b10) model_sel = v;
        @(posedge clk); #2;
        check(remap_sel == model_sel, tag, "remap_sel", {30'd0, remap_sel}, {30'd0, model_sel});
    endtask

    // Scoreboard monitor: compares one expected item per cycle.
    always @(posedge clk) begin
        #2;
        if (rst_n && q.size() > 0) begin
            exp_t e;
            int obs;
            e = q.pop_front();
            case ({ic_valid, dc_valid, sys_valid, int_hit})
                4'b0000: obs = P_NONE;
                4'b1000: obs = P_IC;
                4'b0100: obs = P_DC;
                4'b0010: obs = P_SYS;
                4'b0001: obs = P_INT;
                default: obs = P_MULTI;
            endcase
            if (obs != e.port)
                check(1'b0, e.tag, "port", obs, e.port);
            else if (obs == P_IC)
                check(ic_addr == e.addr, e.tag, "ic_addr", ic_addr, e.addr);
            else if (obs == P_DC)
                check(dc_addr == e.addr && dc_write == e.wr && dc_debug == e.dbg,
                      e.tag, "dc_addr/wr/dbg", {dc_addr[31:2], dc_write, dc_debug},
                      {e.addr[31:2], e.wr, e.dbg});
            else if (obs == P_SYS)
                check(sys_addr == e.addr && sys_write == e.wr && sys_debug == e.dbg,
                      e.tag, "sys_addr/wr/dbg", {sys_addr[31:2], sys_write, sys_debug},
                      {e.addr[31:2], e.wr, e.dbg});
            else
                check(1'b1, e.tag, "port", obs, e.port);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        check(!(ic_valid || dc_valid || sys_valid || int_hit), "R1", "valids in reset",
              {28'd0, ic_valid, dc_valid, sys_valid, int_hit}, 32'd0);
        check(remap_sel == 2'b00, "R1", "remap_sel in reset", {30'd0, remap_sel}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1");

        send(32'h0000_0100, 1, 0, 0, "R2");
        send(32'h1FFF_FFFC, 1, 0, 0, "R2");
        send(32'h0000_0200, 0, 0, 0, "R3");
        send(32'h0000_0010, 1, 1, 0, "R3");
        send(32'h1FFF_FFFE, 1, 0, 0, "R3");
        send(32'h0000_1000, 0, 0, 1, "R3");
        send(32'h2000_0004, 0, 0, 1, "R4");
        send(32'hDFFF_FFFF, 0, 1, 0, "R4");
        send(32'hE010_0000, 1, 0, 0, "R4");
        send(32'hFFFF_FFFC, 0, 0, 1, "R4");
        send(32'hE000_0000, 0, 0, 0, "R5");
        send(32'hE00F_FFFF, 1, 0, 0, "R5");
        idle("R11");
        idle("R11");

        set_sel(2'b01, 0, '0, "R6");
        send(32'h0000_0000, 1, 0, 0, "R6");
        send(32'h03FF_FFFF, 0, 0, 0, "R6");
        send(32'h0400_0000, 0, 0, 0, "R8");

        set_sel(2'b11, 0, '0, "R7");
        send(32'h0000_0004, 1, 0, 0, "R7");
        send(32'h0000_0004, 0, 0, 1, "R7");
        send(32'h2000_0004, 0, 0, 0, "R7");
        send(32'h0800_0010, 0, 0, 0, "R8");
        send(32'h0800_0010, 1, 0, 0, "R8");

        set_sel(2'b10, 0, '0, "R9");
        send(32'h0000_0008, 1, 0, 0, "R9");

        set_sel(2'b00, 1, 32'h0000_0040, "R10");
        send(32'h0000_0040, 1, 0, 0, "R10");
        idle("R11");
        idle("R11");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule